// File: doc/BRIEF.md
# Sixteen-Source Interrupt Aggregator

This block gathers interrupt requests from sixteen peripheral blocks inside an FPGA and funnels them into a single interrupt line toward a host processor. Each source owns one bit in two host-visible registers: an enable register and a pending register. A rising edge on a source's request input sets that source's pending bit. The bit then stays set until software acknowledges it.

The host sees one interrupt line. When the line is raised, software reads the pending register to find which sources fired. It acknowledges each one by writing a one to the matching pending bit. Writing a zero to a bit leaves it as it is. A request from a disabled source is still recorded, so enabling that source later raises the line straight away. Access goes through a plain synchronous port with an address, separate write and read strobes, write data and registered read data.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register, the pending register, `irq_o` and `rdata_o` are all zero.
- R2: The enable register is at address 0x0 and is fully readable and writable. A read with `rd_en_i` high at a clock edge returns the addressed register's value before that edge on `rdata_o` just after the edge. `rdata_o` holds its value while `rd_en_i` is low.
- R3: Pending bit n (address 0x2) is set by a 0-to-1 transition of `req_i[n]` sampled at successive clock edges. A request held high does not set the bit again once it has been cleared.
- R4: Writing the pending register clears every bit where the write data is 1, and leaves every bit where the write data is 0 unchanged.
- R5: If a new rising request edge on bit n coincides with a write that clears bit n, the bit stays set.
- R6: `irq_o` is 1 in the cycle after (pending AND enable) is non-zero, and 0 in the cycle after it is zero.
- R7: A request from a source whose enable bit is 0 still sets its pending bit without raising `irq_o`. Setting that enable bit later raises `irq_o` one cycle after the write.
- R8: Reads from any address other than 0x0 and 0x2 return zero, and writes to them change no register.
- R9: Writing ones to the pending register never sets a bit. Only request edges set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Per-source request inputs, bit n is source n |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
A request edge presented before clock edge k appears in the pending register at edge k, and therefore in `irq_o` at edge k+1. Enable writes and acknowledge writes made at edge k likewise change `irq_o` at edge k+1. Read data appears just after the edge at which the read strobe is sampled. The bench drives every input at the falling edge, advances one rising edge per register stage, and samples at the following falling edge. For the interrupt line it waits one extra rising edge after the stimulus before checking.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int                NSRC      = 16,
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o
);

  logic [NSRC-1:0] mask_q, stat_q, req_q;
  logic [NSRC-1:0] rise, ack, rd_mux;
  logic            sel_mask, sel_stat;

  assign sel_mask = (addr_i == MASK_ADDR);
  assign sel_stat = (addr_i == STAT_ADDR);
  assign rise     = req_i & ~req_q;
  assign ack      = (wr_en_i && sel_stat) ? wdata_i : '0;

  always_comb begin
    if (sel_mask)      rd_mux = mask_q;
    else if (sel_stat) rd_mux = stat_q;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stat_q  <= '0;
      req_q   <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      req_q  <= req_i;
      stat_q <= (stat_q & ~ack) | rise;
      irq_o  <= |(stat_q & mask_q);
      if (wr_en_i && sel_mask) mask_q  <= wdata_i;
      if (rd_en_i)             rdata_o <= rd_mux;
    end
  end

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(req_i & ~req_q)) == $past(req_i & ~req_q))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_stat) |=> ((stat_q & $past(wdata_i & ~(req_i & ~req_q))) == '0)); // R4

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && sel_stat) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |=> irq_o); // R6

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |=> !irq_o); // R6

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && sel_mask) |=> $stable(mask_q)); // R8

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !sel_mask && !sel_stat) |=> (rdata_o == '0)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R2

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  localparam logic [3:0] A_MASK = 4'h0;
  localparam logic [3:0] A_STAT = 4'h2;

  // {enable value, request pattern, expected irq}
  localparam logic [32:0] VEC [6] = '{
    {16'hFFFF, 16'h0001, 1'b1},
    {16'h0000, 16'hFFFF, 1'b0},
    {16'h00FF, 16'hFF00, 1'b0},
    {16'h0F0F, 16'h0101, 1'b1},
    {16'h8000, 16'h8000, 1'b1},
    {16'h7FFF, 16'h8000, 1'b0}
  };

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr_i = a; rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_req(input logic [15:0] v);
    req_i = v;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    chk("R1 irq after reset", {15'd0, irq_o}, 16'h0);
    chk("R1 rdata after reset", rdata_o, 16'h0);
    rd(A_MASK, d); chk("R1 enable reset value", d, 16'h0);
    rd(A_STAT, d); chk("R1 pending reset value", d, 16'h0);

    for (int i = 0; i < 6; i++) begin
      wr(A_MASK, VEC[i][32:17]);
      set_req(VEC[i][16:1]);
      set_req('0);
      chk("R6 irq table", {15'd0, irq_o}, {15'd0, VEC[i][0]});
      rd(A_STAT, d); chk("R3 pending table", d, VEC[i][16:1]);
      wr(A_STAT, 16'hFFFF);
      tick();
      chk("R6 irq drops after ack", {15'd0, irq_o}, 16'h0);
      rd(A_STAT, d); chk("R4 pending cleared", d, 16'h0);
    end

    wr(A_MASK, 16'hA5C3);
    rd(A_MASK, d); chk("R2 enable readback", d, 16'hA5C3);
    tick();
    chk("R2 rdata holds without strobe", rdata_o, 16'hA5C3);
    wr(A_MASK, 16'h0000);

    set_req(16'h00F0); set_req('0);
    wr(A_STAT, 16'h0030);
    rd(A_STAT, d); chk("R4 partial ack", d, 16'h00C0);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d); chk("R4 zero write no effect", d, 16'h00C0);
    wr(A_STAT, 16'h00C0);

    set_req(16'h0004);
    wr(A_STAT, 16'h0004);
    tick(); tick();
    rd(A_STAT, d); chk("R3 held level no retrigger", d, 16'h0000);
    set_req('0); set_req(16'h0004); set_req('0);
    rd(A_STAT, d); chk("R3 new edge sets", d, 16'h0004);
    wr(A_STAT, 16'hFFFF);

    set_req(16'h0020); set_req('0);
    req_i = 16'h0020; addr_i = A_STAT; wdata_i = 16'h0020; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0; wdata_i = '0;
    set_req('0);
    rd(A_STAT, d); chk("R5 edge beats ack", d, 16'h0020);
    wr(A_STAT, 16'h0020);
    rd(A_STAT, d); chk("R5 later ack clears", d, 16'h0000);

    wr(A_MASK, 16'h0000);
    set_req(16'h0200); set_req('0);
    tick();
    chk("R7 masked no irq", {15'd0, irq_o}, 16'h0);
    rd(A_STAT, d); chk("R7 masked still pending", d, 16'h0200);
    wr(A_MASK, 16'h0200);
    tick();
    chk("R7 enable raises irq", {15'd0, irq_o}, 16'h1);

    wr(4'h1, 16'hFFFF);
    wr(4'h4, 16'hFFFF);
    wr(4'hF, 16'hFFFF);
    rd(A_MASK, d); chk("R8 unmapped write ignored mask", d, 16'h0200);
    rd(A_STAT, d); chk("R8 unmapped write ignored pending", d, 16'h0200);
    rd(4'h6, d); chk("R8 unmapped read zero", d, 16'h0000);
    rd(4'h1, d); chk("R8 unmapped read zero odd", d, 16'h0000);

    wr(A_STAT, 16'hFFFF);
    tick();
    chk("R6 irq low after final ack", {15'd0, irq_o}, 16'h0);
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, d); chk("R9 write ones cannot set", d, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule